// File: doc/BRIEF.md
# SPI Register-Access Target

This block connects an external SPI host to an on-chip register file through a simple register port. It is used when the interface-select strap is low. A frame runs while the active-low chip select is held low. The first byte is a command that carries a read/write flag and a 7-bit register address. The bytes after it are data, written to or read from consecutive registers for as long as chip select stays low.

SCK, SI and chip select are asynchronous to the system clock. Each one passes through a synchronizer, and the block finds SCK edges by oversampling. The same logic serves SPI mode 0 (SCK idles low) and mode 3 (SCK idles high), because data is always sampled on rising SCK and driven on falling SCK. The serial output has an enable for a tri-state pad. The enable is raised only during the data phase of a read frame.

Top module: `spi_tgt`

## Requirements
- R1: After reset, `so_oe`, `reg_wr_en` and `reg_rd_en` are all low.
- R2: When `if_sel` is high, SPI traffic causes no register write, no register read and no output enable, and no register changes.
- R3: SI is sampled on rising SCK edges, MSB first. In the first byte of a frame, bit 7 is the direction (0 = write, 1 = read) and bits 6:0 are the start address N.
- R4: In a write frame, each completed data byte gives a one-cycle `reg_wr_en` with `reg_wdata` equal to the byte. Successive bytes go to N, N+1, N+2 and so on, with the address wrapping modulo 128.
- R5: In a read frame, each data byte is fetched with a one-cycle `reg_rd_en` before its first bit is shifted out. `reg_rdata` is taken one clock after the strobe. Successive bytes come from N, N+1 and so on, wrapping modulo 128.
- R6: Read data is driven on `so_o` MSB first, and `so_o` changes only after falling SCK edges.
- R7: `so_oe` is low whenever chip select is high, and it stays low during the command byte of any frame.
- R8: SPI mode 0 and mode 3 frames give identical register traffic.
- R9: If chip select rises before a byte is complete, the partial byte is dropped and no write is made.
- R10: Transfers work correctly with SCK running at one tenth of the system clock (5 MHz with a 50 MHz clock).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| if_sel | input | 1 | Interface-select strap; low enables this target |
| sck_i | input | 1 | SPI serial clock (asynchronous) |
| si_i | input | 1 | SPI serial data in |
| cs_n_i | input | 1 | SPI chip select, active low |
| so_o | output | 1 | SPI serial data out |
| so_oe | output | 1 | Output enable for the SO pad |
| reg_addr | output | 7 | Register port address |
| reg_wdata | output | 8 | Register port write data |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_rd_en | output | 1 | One-cycle register read strobe |
| reg_rdata | input | 8 | Read data, valid the clock after `reg_rd_en` |

## Verification
An SCK edge reaches the core two clocks after the pin changes, because of the synchronizer. Write and read strobes appear one clock after that, and `so_o` takes a new bit one clock after a falling edge is detected. Read data is loaded two clocks after the address strobe. Each SCK half period in the bench lasts five clocks, so every SO bit is settled before the bench samples it just ahead of the next rising edge. The bench drives pins on falling clock edges. Register strobes are compared against a queue of expected writes on falling clock edges. The output enable is checked six clocks after chip select rises, which is past the synchronizer delay.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;
   typedef enum logic [1:0] {
      PH_CMD = 2'd0,
      PH_WR  = 2'd1,
      PH_RD  = 2'd2
   } phase_e;
endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
   parameter int               WIDTH   = 3,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_depth
      $error("spi_tgt_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      stg[s] <= RST_VAL;
         else if (s == 0) stg[s] <= d;
         else             stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_tgt_edge.sv
module spi_tgt_edge #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   output logic rise,
   output logic fall
);
   logic level_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_q <= RST_VAL;
      else        level_q <= level;
   end

   assign rise = level & ~level_q;
   assign fall = ~level & level_q;
endmodule

// File: rtl/spi_tgt_core.sv
module spi_tgt_core
   import spi_tgt_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              sck_rise,
   input  logic              sck_fall,
   input  logic              si,
   input  logic [DATA_W-1:0] reg_rdata,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              reg_wr_en,
   output logic              reg_rd_en,
   output logic              so_bit,
   output logic              rd_phase
);
   localparam int CNT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   if (DATA_W != ADDR_W + 1) begin : g_bad_fmt
      $error("spi_tgt_core: command byte must hold flag plus address");
   end

   phase_e            phase;
   logic [CNT_W-1:0]  bit_cnt;
   logic [DATA_W-1:0] rx_sh;
   logic [DATA_W-1:0] tx_sh;
   logic [ADDR_W-1:0] ptr;
   logic              fetch_q;
   logic [DATA_W-1:0] rx_byte;
   logic              last_bit;

   assign rx_byte  = {rx_sh[DATA_W-2:0], si};
   assign last_bit = (bit_cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_CMD;
         bit_cnt   <= '0;
         rx_sh     <= '0;
         tx_sh     <= '0;
         ptr       <= '0;
         fetch_q   <= 1'b0;
         reg_addr  <= '0;
         reg_wdata <= '0;
         reg_wr_en <= 1'b0;
         reg_rd_en <= 1'b0;
         so_bit    <= 1'b0;
      end else begin
         reg_wr_en <= 1'b0;
         reg_rd_en <= 1'b0;
         fetch_q   <= reg_rd_en;
         if (!active) begin
            phase   <= PH_CMD;
            bit_cnt <= '0;
         end else begin
            if (sck_rise) begin
               rx_sh   <= rx_byte;
               bit_cnt <= last_bit ? '0 : bit_cnt + CNT_W'(1);
               if (last_bit) begin
                  case (phase)
                     PH_CMD: begin
                        if (rx_byte[DATA_W-1]) begin
                           phase     <= PH_RD;
                           reg_rd_en <= 1'b1;
                           reg_addr  <= rx_byte[ADDR_W-1:0];
                           ptr       <= rx_byte[ADDR_W-1:0] + ADDR_W'(1);
                        end else begin
                           phase <= PH_WR;
                           ptr   <= rx_byte[ADDR_W-1:0];
                        end
                     end
                     PH_WR: begin
                        reg_wr_en <= 1'b1;
                        reg_addr  <= ptr;
                        reg_wdata <= rx_byte;
                        ptr       <= ptr + ADDR_W'(1);
                     end
                     default: begin
                        reg_rd_en <= 1'b1;
                        reg_addr  <= ptr;
                        ptr       <= ptr + ADDR_W'(1);
                     end
                  endcase
               end
            end
            if (sck_fall && phase == PH_RD) begin
               so_bit <= tx_sh[DATA_W-1];
               tx_sh  <= tx_sh << 1;
            end
         end
         if (fetch_q) tx_sh <= reg_rdata;
      end
   end

   assign rd_phase = (phase == PH_RD);
endmodule

// File: rtl/spi_tgt.sv
module spi_tgt #(
   parameter int ADDR_W      = 7,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              if_sel,
   input  logic              sck_i,
   input  logic              si_i,
   input  logic              cs_n_i,
   output logic              so_o,
   output logic              so_oe,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              reg_wr_en,
   output logic              reg_rd_en,
   input  logic [DATA_W-1:0] reg_rdata
);
   logic [2:0] pins_s;
   logic       cs_s, sck_s, si_s;
   logic       sck_rise, sck_fall;
   logic       active, rd_phase;

   spi_tgt_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({cs_n_i, sck_i, si_i}), .q(pins_s)
   );
   assign {cs_s, sck_s, si_s} = pins_s;

   spi_tgt_edge #(.RST_VAL(1'b0)) u_edge (
      .clk(clk), .rst_n(rst_n), .level(sck_s), .rise(sck_rise), .fall(sck_fall)
   );

   assign active = ~if_sel & ~cs_s;

   spi_tgt_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_core (
      .clk(clk), .rst_n(rst_n), .active(active),
      .sck_rise(sck_rise), .sck_fall(sck_fall), .si(si_s),
      .reg_rdata(reg_rdata), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
      .so_bit(so_o), .rd_phase(rd_phase)
   );

   assign so_oe = active & rd_phase;
endmodule

// File: rtl/spi_tgt_chk.sv
module spi_tgt_chk #(
   parameter int ADDR_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              if_sel,
   input logic              cs_sync,
   input logic              so_oe,
   input logic              reg_wr_en,
   input logic              reg_rd_en,
   input logic [ADDR_W-1:0] reg_addr
);
   logic              wr_seen, rd_seen;
   logic [ADDR_W-1:0] wr_last, rd_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_seen <= 1'b0; rd_seen <= 1'b0;
         wr_last <= '0;   rd_last <= '0;
      end else if (cs_sync) begin
         wr_seen <= 1'b0; rd_seen <= 1'b0;
      end else begin
         if (reg_wr_en) begin wr_seen <= 1'b1; wr_last <= reg_addr; end
         if (reg_rd_en) begin rd_seen <= 1'b1; rd_last <= reg_addr; end
      end
   end

   p_oe_off_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cs_sync |-> !so_oe);
   p_strap_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (if_sel && $past(if_sel)) |-> (!reg_wr_en && !reg_rd_en && !so_oe));
   p_wr_incr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && wr_seen) |-> (reg_addr == wr_last + ADDR_W'(1)));
   p_rd_incr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd_en && rd_seen) |-> (reg_addr == rd_last + ADDR_W'(1)));
   p_dir_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr_en && reg_rd_en));
   p_rd_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_en |=> !reg_rd_en);
endmodule

bind spi_tgt spi_tgt_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .if_sel(if_sel), .cs_sync(cs_s),
   .so_oe(so_oe), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
   .reg_addr(reg_addr)
);

// File: tb/spi_tgt_test.sv
module spi_tgt_test;
   localparam int H = 5; // R10: SCK half period of 5 clocks = clk/10

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       if_sel = 1'b0, sck = 1'b0, si = 1'b0, cs_n = 1'b1;
   logic       so_o, so_oe, reg_wr_en, reg_rd_en;
   logic [6:0] reg_addr;
   logic [7:0] reg_wdata, reg_rdata;

   always #10 clk = ~clk;

   spi_tgt uut (
      .clk(clk), .rst_n(rst_n), .if_sel(if_sel), .sck_i(sck), .si_i(si),
      .cs_n_i(cs_n), .so_o(so_o), .so_oe(so_oe), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
      .reg_rdata(reg_rdata)
   );

   int checks = 0, errors = 0, oe_hits = 0;
   bit done = 1'b0;
   logic [7:0] mem [128];
   logic [7:0] exp_mem [128];
   logic [14:0] wr_q [$];

   initial for (int i = 0; i < 128; i++) begin
      mem[i] = 8'(i) ^ 8'hA5;
      exp_mem[i] = 8'(i) ^ 8'hA5;
   end
   initial reg_rdata = 8'h00;

   always @(posedge clk) begin
      if (reg_rd_en) reg_rdata <= mem[reg_addr];
      if (reg_wr_en) mem[reg_addr] <= reg_wdata;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && so_oe) oe_hits++;
      if (rst_n && reg_wr_en) begin
         if (wr_q.size() == 0) check(1'b0, "R4/R9 unexpected write", {reg_addr, reg_wdata}, 0);
         else begin
            logic [14:0] e;
            e = wr_q.pop_front();
            check({reg_addr, reg_wdata} == e, "R4 write addr/data", {reg_addr, reg_wdata}, e);
         end
      end
   end

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   // oe_exp: 0 must be off, 1 must be on, 2 don't care
   task automatic xbits(input logic [7:0] tx, input int nb, input int oe_exp,
                        output logic [7:0] rx);
      rx = '0;
      for (int b = 7; b > 7 - nb; b--) begin
         sck = 1'b0;
         si  = tx[b];
         wait_clk(H);
         rx[b] = so_o;
         if (oe_exp == 0) check(so_oe == 1'b0, "R7 oe off in command", so_oe, 0);
         if (oe_exp == 1) check(so_oe == 1'b1, "R5 oe on in read data", so_oe, 1);
         sck = 1'b1;
         wait_clk(H);
      end
   endtask

   task automatic frame_start(input bit mode3);
      sck = mode3;
      wait_clk(H);
      cs_n = 1'b0;
      wait_clk(H);
   endtask

   task automatic frame_end(input bit mode3);
      if (!mode3) begin sck = 1'b0; wait_clk(H); end
      cs_n = 1'b1;
      wait_clk(6);
      check(so_oe == 1'b0, "R7 oe off after cs high", so_oe, 0);
      wait_clk(H);
   endtask

   task automatic spi_write(input bit mode3, input logic [6:0] a,
                            input logic [7:0] d0, d1, d2, input int n, input bit expect_wr);
      logic [7:0] rx;
      logic [7:0] d [3];
      d[0] = d0; d[1] = d1; d[2] = d2;
      frame_start(mode3);
      xbits({1'b0, a}, 8, 0, rx); // R3 command: bit7 = 0 write
      for (int i = 0; i < n; i++) begin
         if (expect_wr) begin
            wr_q.push_back({7'(a + 7'(i)), d[i]});
            exp_mem[7'(a + 7'(i))] = d[i];
         end
         xbits(d[i], 8, 0, rx);
      end
      frame_end(mode3);
      check(wr_q.size() == 0, "R4 all writes seen", wr_q.size(), 0);
   endtask

   task automatic spi_read(input bit mode3, input logic [6:0] a, input int n, input string req);
      logic [7:0] rx;
      frame_start(mode3);
      xbits({1'b1, a}, 8, 0, rx); // R3 command: bit7 = 1 read
      for (int i = 0; i < n; i++) begin
         xbits(8'h00, 8, 1, rx);
         check(rx == exp_mem[7'(a + 7'(i))], req, rx, exp_mem[7'(a + 7'(i))]); // R6 MSB first
      end
      frame_end(mode3);
   endtask

   initial begin
      logic [7:0] rx;
      wait_clk(4);
      rst_n = 1'b1;
      wait_clk(3);
      check(!so_oe && !reg_wr_en && !reg_rd_en, "R1 reset state",
            {so_oe, reg_wr_en, reg_rd_en}, 0);

      // R4 mode 0 burst
      spi_write(1'b0, 7'h10, 8'h3C, 8'hC3, 8'h5A, 3, 1'b1);
      // R5 R6 mode 0 burst read
      spi_read(1'b0, 7'h10, 3, "R5 R6 mode0 read");
      // R8 mode 3 write with address wrap (R4)
      spi_write(1'b1, 7'h7E, 8'h81, 8'h7E, 8'hF0, 3, 1'b1);
      // R8 mode 3 read across the wrap (R5)
      spi_read(1'b1, 7'h7F, 2, "R8 R5 mode3 wrap read");
      spi_read(1'b0, 7'h7E, 3, "R8 mode0 sees mode3 writes");

      // R9 abort mid-byte
      frame_start(1'b0);
      xbits({1'b0, 7'h20}, 8, 0, rx);
      xbits(8'hFF, 4, 0, rx);
      cs_n = 1'b1;
      wait_clk(20);
      check(wr_q.size() == 0, "R9 no write on abort", wr_q.size(), 0);
      spi_read(1'b0, 7'h20, 1, "R9 register unchanged after abort");

      // R2 strap high: SPI ignored
      if_sel = 1'b1;
      oe_hits = 0;
      spi_write(1'b0, 7'h30, 8'h11, 8'h22, 8'h33, 3, 1'b0);
      frame_start(1'b0);
      xbits({1'b1, 7'h30}, 8, 2, rx);
      xbits(8'h00, 8, 2, rx);
      frame_end(1'b0);
      check(oe_hits == 0, "R2 no oe with strap high", oe_hits, 0);
      if_sel = 1'b0;
      wait_clk(4);
      spi_read(1'b1, 7'h30, 3, "R2 registers unchanged");

      finish_run();
   end
endmodule